// File: doc/BRIEF.md
# Ripple Bit-Slice Integer ALU

This block is a purely combinational integer ALU built from a chain of identical one-bit slices. It is 4 bits wide by default and accepts any width from 2 to 32. Every slice holds its own conditional inverters on both operands, a full adder and a four-way output selector. Carries ripple upward from slice to slice. A 4-bit function code sets the operation. Its top two bits invert operand A and operand B. The bottom two bits pick which value each slice drives onto its result bit.

The set-less-than result comes from a loop back through the chain. The least significant slice takes the raw adder sum of the most significant slice as its selectable comparison input. Every other slice has that input held at zero. Alongside the result word the block produces a four-bit condition code that holds carry, overflow, negative and zero.

A parameter chooses how the operand inverters are built, either as XOR gates or as two-way multiplexers. The two choices behave the same.

Top module: `alu_bitslice_top`

## Requirements
- R1: When function bit 3 is 1, operand A is bit-inverted before it reaches the logic gates and the adder of every slice. For example, code 1000 gives (~A) & B.
- R2: When function bit 2 is 1, operand B is bit-inverted in every slice and the carry into slice 0 is 1. Code 0110 therefore yields A - B modulo 2^WIDTH.
- R3: Function bits 1:0 select each slice's output: 00 gives the AND of the effective operands, 01 gives their OR, 10 gives the adder sum and 11 gives the slice's comparison input.
- R4: Under select 11, result bit 0 equals the most significant bit of the raw sum A_eff + B_eff + bit2, and all higher result bits are 0. No overflow correction is applied: for code 0111 with A=0111 and B=1000 the result is 0001.
- R5: Code 0010 yields A + B modulo 2^WIDTH through a ripple carry chain that starts with a carry-in of 0.
- R6: The condition-code output carries C on bit 3, V on bit 2, N on bit 1 and Z on bit 0. C is the carry out of the most significant slice for every function code.
- R7: V equals the carry into the most significant slice XOR the carry out of it, for every function code.
- R8: N equals the most significant result bit. Z is 1 exactly when every result bit is 0.
- R9: Code 1100 inverts both operands and selects AND, which yields the NOR of A and B.
- R10: WIDTH outside 2..32, or an inverter style other than 0 or 1, is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| fn | input | 4 | Function code: bit 3 inverts A, bit 2 inverts B and sets the carry-in, bits 1:0 select the output |
| result | output | WIDTH | Result word |
| cvnz | output | 4 | Condition code: C, V, N, Z from bit 3 down to bit 0 |

## Verification
All sixteen function codes are applied with every operand pair of the 4-bit build. This covers the unnamed codes as well as the five common operations, so the effect of each inverter can be told apart from the effect of the selector. The pairs that cross the signed boundary show that the overflow flag and the unflagged comparison follow the raw sum sign. Those pairs are exactly where a corrected comparison or a sign-based overflow flag would disagree. A few directed pairs with literal expected values pin down subtraction, the overflowing comparison, NOR, addition wrap-around and AND with its flags.

// File: rtl/alu_bs_pkg.sv
package alu_bs_pkg;

   // Positions of the control bits inside the function code
   localparam int unsigned FN_INV_A_BIT = 3;
   localparam int unsigned FN_INV_B_BIT = 2;

   // Output selector encoding (function bits 1:0)
   typedef enum logic [1:0] {
      SEL_AND = 2'b00,
      SEL_OR  = 2'b01,
      SEL_SUM = 2'b10,
      SEL_CMP = 2'b11
   } sel_e;

   // Condition code layout, most significant field first
   typedef struct packed {
      logic c;
      logic v;
      logic n;
      logic z;
   } cc_t;

   // Inverter implementation variants
   localparam int unsigned INV_XOR = 0;
   localparam int unsigned INV_MUX = 1;

endpackage

// File: rtl/alu_opnd_inv.sv
module alu_opnd_inv #(
   parameter int unsigned STYLE = 0
) (
   input  logic d_in,
   input  logic invert,
   output logic d_out
);
   import alu_bs_pkg::*;

   generate
      if (STYLE == INV_XOR) begin : g_xor
         assign d_out = d_in ^ invert;
      end else begin : g_mux
         always_comb begin
            if (invert) d_out = ~d_in;
            else        d_out = d_in;
         end
      end
   endgenerate
endmodule

// File: rtl/alu_full_add.sv
module alu_full_add (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   logic half;

   assign half = x ^ y;
   assign s    = half ^ ci;
   assign co   = (x & y) | (half & ci);
endmodule

// File: rtl/alu_sel4.sv
module alu_sel4 (
   input  logic [1:0] sel,
   input  logic       in0,
   input  logic       in1,
   input  logic       in2,
   input  logic       in3,
   output logic       y
);
   always_comb begin
      unique case (sel)
         2'b00:   y = in0;
         2'b01:   y = in1;
         2'b10:   y = in2;
         default: y = in3;
      endcase
   end
endmodule

// File: rtl/alu_slice.sv
module alu_slice #(
   parameter int unsigned INV_STYLE = 0
) (
   input  logic       a_in,
   input  logic       b_in,
   input  logic [3:0] fn,
   input  logic       c_in,
   input  logic       cmp_in,
   output logic       res,
   output logic       c_out,
   output logic       sum_out
);
   import alu_bs_pkg::*;

   logic a_eff;
   logic b_eff;
   logic sum;
   logic and_v;
   logic or_v;

   alu_opnd_inv #(.STYLE(INV_STYLE)) u_inv_a (
      .d_in(a_in), .invert(fn[FN_INV_A_BIT]), .d_out(a_eff)
   );

   alu_opnd_inv #(.STYLE(INV_STYLE)) u_inv_b (
      .d_in(b_in), .invert(fn[FN_INV_B_BIT]), .d_out(b_eff)
   );

   alu_full_add u_fa (
      .x(a_eff), .y(b_eff), .ci(c_in), .s(sum), .co(c_out)
   );

   assign and_v   = a_eff & b_eff;
   assign or_v    = a_eff | b_eff;
   assign sum_out = sum;

   alu_sel4 u_sel (
      .sel(fn[1:0]), .in0(and_v), .in1(or_v), .in2(sum), .in3(cmp_in), .y(res)
   );

   always_comb begin
      // R3
      if (fn[1:0] == SEL_SUM)
         sum_route_chk: assert (res == (a_eff ^ b_eff ^ c_in));
      // R1
      if (fn[1:0] == SEL_AND)
         and_inv_chk: assert (res == ((fn[FN_INV_A_BIT] ? ~a_in : a_in) & b_eff));
      // R5
      if (a_eff && b_eff)
         carry_gen_chk: assert (c_out);
      // R5
      if (!a_eff && !b_eff)
         carry_kill_chk: assert (!c_out);
   end
endmodule

// File: rtl/alu_cc_gen.sv
module alu_cc_gen #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] res,
   input  logic             msb_cin,
   input  logic             msb_cout,
   output logic [3:0]       cc
);
   import alu_bs_pkg::*;

   cc_t flags;

   always_comb begin
      flags.c = msb_cout;
      flags.v = msb_cin ^ msb_cout;
      flags.n = res[WIDTH-1];
      flags.z = (res == '0);
   end

   assign cc = flags;
endmodule

// File: rtl/alu_bitslice_top.sv
module alu_bitslice_top #(
   parameter int unsigned WIDTH     = 4,
   parameter int unsigned INV_STYLE = 0
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [3:0]       fn,
   output logic [WIDTH-1:0] result,
   output logic [3:0]       cvnz
);
   import alu_bs_pkg::*;

   localparam int unsigned MSB = WIDTH - 1;

   // R10
   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("alu_bitslice_top: WIDTH must lie in 2..32");
      end
      if (INV_STYLE != INV_XOR && INV_STYLE != INV_MUX) begin : g_bad_style
         $error("alu_bitslice_top: INV_STYLE must be 0 or 1");
      end
   endgenerate

   logic msb_sum;
   logic msb_cin;
   logic msb_cout;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic ci;
         logic co;
         logic so;
         logic cmp;

         if (i == 0) begin : g_lsb
            assign ci  = fn[FN_INV_B_BIT];
            assign cmp = msb_sum;
         end else begin : g_upper
            assign ci  = g_bit[i-1].co;
            assign cmp = 1'b0;
         end

         alu_slice #(.INV_STYLE(INV_STYLE)) u_slice (
            .a_in(opa[i]), .b_in(opb[i]), .fn(fn), .c_in(ci),
            .cmp_in(cmp), .res(result[i]), .c_out(co), .sum_out(so)
         );

         if (i == MSB) begin : g_top
            assign msb_sum  = so;
            assign msb_cin  = ci;
            assign msb_cout = co;
         end

         always_comb begin
            // R3
            if (fn[1:0] == SEL_SUM)
               slice_sum_chk: assert (so == result[i]);
         end
      end
   endgenerate

   alu_cc_gen #(.WIDTH(WIDTH)) u_cc (
      .res(result), .msb_cin(msb_cin), .msb_cout(msb_cout), .cc(cvnz)
   );

   always_comb begin
      // R4
      if (fn[1:0] == SEL_CMP)
         cmp_upper_zero_chk: assert (result[MSB:1] == '0);
      // R7
      if (fn[1:0] == SEL_SUM)
         ovf_sign_chk: assert (cvnz[2] ==
            (((opa[MSB] ^ fn[FN_INV_A_BIT]) == (opb[MSB] ^ fn[FN_INV_B_BIT])) &&
             (result[MSB] != (opa[MSB] ^ fn[FN_INV_A_BIT]))));
      // R8
      zero_flag_chk: assert (cvnz[0] == (result == '0));
   end
endmodule

// File: tb/alu_bitslice_top_test.sv
module alu_bitslice_top_test;
   localparam int W = 4;

   typedef struct {
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [3:0]   f;
      logic [W-1:0] exp_res;
      logic [3:0]   exp_cc;
      string        tag;
   } item_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic [3:0]   fn  = '0;
   logic [W-1:0] result;
   logic [3:0]   cvnz;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;
   item_t sb_q[$];

   always #4 clk = ~clk;

   alu_bitslice_top #(.WIDTH(W), .INV_STYLE(0)) uut (
      .opa(opa), .opb(opb), .fn(fn), .result(result), .cvnz(cvnz)
   );

   // Reference model written from the requirements
   function automatic void ref_model(input logic [W-1:0] a, input logic [W-1:0] b,
                                     input logic [3:0] f,
                                     output logic [W-1:0] r, output logic [3:0] cc);
      logic [W-1:0] ae, be;
      logic [W:0]   full;
      logic [W-1:0] low;
      logic         cin_msb;
      ae   = f[3] ? ~a : a;                               // R1
      be   = f[2] ? ~b : b;                               // R2
      full = {1'b0, ae} + {1'b0, be} + {{W{1'b0}}, f[2]}; // R5
      low  = {1'b0, ae[W-2:0]} + {1'b0, be[W-2:0]} + {{(W-1){1'b0}}, f[2]};
      cin_msb = low[W-1];
      case (f[1:0])                                       // R3
         2'b00: r = ae & be;
         2'b01: r = ae | be;
         2'b10: r = full[W-1:0];
         default: r = {{(W-1){1'b0}}, full[W-1]};         // R4
      endcase
      cc[3] = full[W];                                    // R6
      cc[2] = cin_msb ^ full[W];                          // R7
      cc[1] = r[W-1];                                     // R8
      cc[0] = (r == '0);
   endfunction

   function automatic string tag_for(input logic [3:0] f);
      if (f == 4'b0010) return "R5";
      if (f == 4'b0110) return "R2";
      if (f == 4'b0111) return "R4";
      if (f == 4'b1100) return "R9";
      if (f[3])         return "R1";
      return "R3";
   endfunction

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] f);
      item_t it;
      @(posedge clk);
      opa = a; opb = b; fn = f;
      it.a = a; it.b = b; it.f = f; it.tag = tag_for(f);
      ref_model(a, b, f, it.exp_res, it.exp_cc);
      sb_q.push_back(it);
   endtask

   task automatic drive_lit(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] f,
                            input logic [W-1:0] r, input logic [3:0] cc, input string tag);
      item_t it;
      @(posedge clk);
      opa = a; opb = b; fn = f;
      it.a = a; it.b = b; it.f = f; it.exp_res = r; it.exp_cc = cc; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic cmp_bit(input string tag, input string what, input logic act,
                          input logic exp, input item_t it);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s a=%h b=%h f=%b actual=%b expected=%b",
                  tag, what, it.a, it.b, it.f, act, exp);
      end
   endtask

   // Monitor: pops expected items half a cycle after they were driven
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            compared++;
            if (result !== it.exp_res) begin
               mismatched++;
               $display("FAIL %s result a=%h b=%h f=%b actual=%h expected=%h",
                        it.tag, it.a, it.b, it.f, result, it.exp_res);
            end
            cmp_bit("R6", "C", cvnz[3], it.exp_cc[3], it);
            cmp_bit("R7", "V", cvnz[2], it.exp_cc[2], it);
            cmp_bit("R8", "N", cvnz[1], it.exp_cc[1], it);
            cmp_bit("R8", "Z", cvnz[0], it.exp_cc[0], it);
         end
      end
   end

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Quiet state: all zero inputs give result 0 with Z set (R8)
      drive_lit(4'h0, 4'h0, 4'b0000, 4'h0, 4'b0001, "R8");
      // R2: 3 - 5 = 1110, no carry, no overflow, negative
      drive_lit(4'h3, 4'h5, 4'b0110, 4'hE, 4'b0010, "R2");
      // R4: 7 vs -8 overflows; raw sign taken, result 1, V set
      drive_lit(4'h7, 4'h8, 4'b0111, 4'h1, 4'b0100, "R4");
      // R9: NOR of 0101 and 0011
      drive_lit(4'h5, 4'h3, 4'b1100, 4'h8, 4'b1110, "R9");
      // R5/R6: 15 + 1 wraps to 0 with carry and zero
      drive_lit(4'hF, 4'h1, 4'b0010, 4'h0, 4'b1001, "R5");
      // R3: AND of 1100 and 1010, flags from the adder (R7)
      drive_lit(4'hC, 4'hA, 4'b0000, 4'h8, 4'b1110, "R3");
      // Exhaustive sweep of codes and operand pairs
      for (int f = 0; f < 16; f++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               drive(W'(a), W'(b), 4'(f));
      repeat (3) @(posedge clk);
      report();
   end
endmodule